// File: doc/BRIEF.md
# All-Switch Emergency Enable Unlock

This block guards a drastic command: turning on every output switch of a bridge at the same moment. That command must never fire by accident. So the block only grants it after three fixed key values arrive in order, in consecutive register writes to one dedicated address. At the moment the third key lands, the block also checks two conditions. Every one of the six gate-command inputs must already be high, and the driver must be in direct drive mode.

The serial decoder in front of the block presents each register write as a single-cycle strobe with address and data. The block answers with one level, the all-on enable, which the output stage uses to drive every switch. Once granted, the enable stays up only while direct mode holds and all six command inputs stay high. If either condition goes away, the enable drops.

Top module: `allon_unlock_gate`

## Requirements
- R1: After reset the all-on enable is low and the key sequence waits for its first key.
- R2: Three writes to the key address are needed, carrying KEY0 (default 0xA5), then KEY1 (0x5A), then KEY2 (0xC3), with no other write between them. If direct mode is high and all six command inputs are high when the KEY2 write is sampled, the enable goes high on the clock edge that samples that write, so it is visible one cycle after the strobe is presented.
- R3: A write that does not match the next expected key returns the sequence to waiting for KEY0. This covers a write to any other address, and any other data value at the key address. A KEY0 value arriving mid-sequence also counts as a mismatch: it does not restart the sequence. Only a complete new three-key sequence can then grant the enable.
- R4: Cycles without a write strobe neither advance nor reset the sequence, and never raise the enable.
- R5: If any of the six command inputs is low when the KEY2 write is sampled, activation is refused. The enable stays low and the sequence returns to waiting for KEY0.
- R6: Direct mode low on any sampled cycle resets the sequence. If it is low when the KEY2 write is sampled, activation is refused.
- R7: While the enable is high, direct mode is high and all six inputs are high, the enable stays high regardless of any writes.
- R8: If direct mode is low, or any command input is low, on a sampled edge, the enable is low after that edge.
- R9: Command inputs that are low during the KEY0 or KEY1 write do not reset the sequence. Only their level at the KEY2 write qualifies activation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Single-cycle register write strobe |
| wrAddr | input | ADDR_W (6) | Write address |
| wrData | input | DATA_W (8) | Write data |
| gateIn | input | NUM_IN (6) | Gate-command input levels, high-side and low-side |
| directMode | input | 1 | High when the driver runs in direct drive mode |
| allOn | output | 1 | All-switch enable |

## Verification
Every result of this block is due exactly one clock edge after its cause.

- The enable rises on the edge that samples the KEY2 write.
- The enable falls on the edge that samples a lost qualifier.
- A sequence reset becomes visible only as the outcome of later key writes.

The bench therefore drives all inputs on the falling edge and reads the enable on the next falling edge, half a period after the edge that sampled the stimulus. Sweeps over every data value, every address, every input pattern and both mode levels at each sequence position give the expected enable from a closed-form rule.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  // Position in the three-key sequence: which key is expected next.
  typedef enum logic [1:0] {
    WAIT_K0 = 2'd0,
    WAIT_K1 = 2'd1,
    WAIT_K2 = 2'd2
  } keyStage_e;

  // Strobes from control to datapath for the enable register.
  typedef struct packed {
    logic setOn;
    logic clrOn;
  } gateStrobe_t;

endpackage

// File: rtl/unlock_datapath.sv
module unlock_datapath
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int NUM_IN = 6,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 6'h2C,
  parameter logic [DATA_W-1:0] KEY0 = 8'hA5,
  parameter logic [DATA_W-1:0] KEY1 = 8'h5A,
  parameter logic [DATA_W-1:0] KEY2 = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_IN-1:0] gateIn,
  input  logic              directMode,
  input  keyStage_e         stage,
  input  gateStrobe_t       strobe,
  output logic              keyHit,
  output logic              qualOk,
  output logic              allOn
);

  localparam int NUM_KEYS = 3;

  logic [DATA_W-1:0] keyTable [NUM_KEYS];
  logic [DATA_W-1:0] expectKey;
  logic              addrHit;
  logic              allHigh;

  assign keyTable[0] = KEY0;
  assign keyTable[1] = KEY1;
  assign keyTable[2] = KEY2;

  always_comb begin
    expectKey = keyTable[0];
    for (int i = 1; i < NUM_KEYS; i++) begin
      if (int'(stage) == i) expectKey = keyTable[i];
    end
  end

  assign addrHit = (wrAddr == KEY_ADDR);
  assign keyHit  = addrHit && (wrData == expectKey);
  assign allHigh = &gateIn;
  assign qualOk  = directMode && allHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             allOn <= 1'b0;
    else if (strobe.clrOn) allOn <= 1'b0;
    else if (strobe.setOn) allOn <= 1'b1;
  end

endmodule

// File: rtl/unlock_ctrl.sv
module unlock_ctrl
  import unlock_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        directMode,
  input  logic        keyHit,
  input  logic        qualOk,
  output keyStage_e   stage,
  output gateStrobe_t strobe
);

  keyStage_e stageNext;

  always_comb begin
    stageNext = stage;
    if (!directMode) begin
      stageNext = WAIT_K0;
    end else if (wrEn) begin
      if (!keyHit) begin
        stageNext = WAIT_K0;
      end else begin
        unique case (stage)
          WAIT_K0: stageNext = WAIT_K1;
          WAIT_K1: stageNext = WAIT_K2;
          default: stageNext = WAIT_K0;
        endcase
      end
    end
  end

  always_comb begin
    strobe.clrOn = !qualOk;
    strobe.setOn = wrEn && keyHit && (stage == WAIT_K2) && qualOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= WAIT_K0;
    else       stage <= stageNext;
  end

endmodule

// File: rtl/allon_unlock_gate.sv
module allon_unlock_gate
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int NUM_IN = 6,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 6'h2C,
  parameter logic [DATA_W-1:0] KEY0 = 8'hA5,
  parameter logic [DATA_W-1:0] KEY1 = 8'h5A,
  parameter logic [DATA_W-1:0] KEY2 = 8'hC3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_IN-1:0] gateIn,
  input  logic              directMode,
  output logic              allOn
);

  keyStage_e   stage;
  gateStrobe_t strobe;
  logic        keyHit;
  logic        qualOk;

  unlock_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .directMode (directMode),
    .keyHit     (keyHit),
    .qualOk     (qualOk),
    .stage      (stage),
    .strobe     (strobe)
  );

  unlock_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_IN   (NUM_IN),
    .KEY_ADDR (KEY_ADDR),
    .KEY0     (KEY0),
    .KEY1     (KEY1),
    .KEY2     (KEY2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .gateIn     (gateIn),
    .directMode (directMode),
    .stage      (stage),
    .strobe     (strobe),
    .keyHit     (keyHit),
    .qualOk     (qualOk),
    .allOn      (allOn)
  );

endmodule

// File: rtl/allon_unlock_gate_chk.sv
module allon_unlock_gate_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int NUM_IN = 6,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 6'h2C,
  parameter logic [DATA_W-1:0] KEY2 = 8'hC3
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [NUM_IN-1:0] gateIn,
  input logic              directMode,
  input logic              allOn
);

  // A rising enable must come from a qualified final-key write (R2, R5, R6).
  p_rise_needs_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(allOn) |-> $past(wrEn && (wrAddr == KEY_ADDR) && (wrData == KEY2)
                           && directMode && (&gateIn)));

  // No write strobe, no rise (R4).
  p_idle_no_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!allOn && !wrEn) |=> !allOn);

  // Enable holds while qualified (R7).
  p_hold_on_r7: assert property (@(posedge clk) disable iff (!rstN)
    (allOn && directMode && (&gateIn)) |=> allOn);

  // Lost qualifier drops the enable (R8).
  p_drop_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!directMode || !(&gateIn)) |=> !allOn);

  // Enable low while in reset (R1).
  always_ff @(posedge clk) begin
    if (!rstN) p_reset_low_r1: assert (!allOn);
  end

endmodule

bind allon_unlock_gate allon_unlock_gate_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_IN   (NUM_IN),
  .KEY_ADDR (KEY_ADDR),
  .KEY2     (KEY2)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .gateIn     (gateIn),
  .directMode (directMode),
  .allOn      (allOn)
);

// File: tb/sim_allon_unlock_gate.sv
`timescale 1ns/1ps
module sim_allon_unlock_gate;

  localparam logic [5:0] KA = 6'h2C;
  localparam logic [7:0] K0 = 8'hA5;
  localparam logic [7:0] K1 = 8'h5A;
  localparam logic [7:0] K2 = 8'hC3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [5:0] gateIn = 6'h3F;
  logic       directMode = 1'b1;
  logic       allOn;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  allon_unlock_gate u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .gateIn(gateIn), .directMode(directMode), .allOn(allOn)
  );

  function automatic logic [7:0] keyAt(int s);
    return (s == 0) ? K0 : (s == 1) ? K1 : K2;
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: allOn=%0b expected %0b", req, act, exp);
    end
  endtask

  // Present one write; returns at the next falling edge, after it was sampled.
  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drop direct mode for one cycle: clears enable and sequence.
  task automatic flush();
    directMode = 1'b0; gateIn = 6'h3F;
    @(negedge clk);
    directMode = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: allOn=%0b expected finish", allOn);
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    idle(2);
    check(allOn, 1'b0, "R1");
    rstN = 1'b1;
    idle(1);
    check(allOn, 1'b0, "R1");
    // R1: a lone final key right after reset must not grant.
    wr(KA, K2);
    check(allOn, 1'b0, "R1");
    flush();

    // R2 basic sequence
    wr(KA, K0); check(allOn, 1'b0, "R2");
    wr(KA, K1); check(allOn, 1'b0, "R2");
    wr(KA, K2); check(allOn, 1'b1, "R2");
    flush();

    // R3: every data value at every position
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 256; d++) begin
        for (int p = 0; p < s; p++) wr(KA, keyAt(p));
        wr(KA, 8'(d));
        for (int p = s + 1; p < 3; p++) wr(KA, keyAt(p));
        check(allOn, (8'(d) == keyAt(s)), "R3");
        flush();
      end
    end

    // R3: every address at every position
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 64; a++) begin
        for (int p = 0; p < s; p++) wr(KA, keyAt(p));
        wr(6'(a), keyAt(s));
        for (int p = s + 1; p < 3; p++) wr(KA, keyAt(p));
        check(allOn, (6'(a) == KA), "R3");
        flush();
      end
    end

    // R3: KEY0 mid-sequence does not restart
    wr(KA, K0); wr(KA, K0); wr(KA, K1); wr(KA, K2);
    check(allOn, 1'b0, "R3");
    flush();

    // R4: idle gaps between keys
    wr(KA, K0); idle(5); check(allOn, 1'b0, "R4");
    wr(KA, K1); idle(7); check(allOn, 1'b0, "R4");
    wr(KA, K2); check(allOn, 1'b1, "R4");
    flush();

    // R5/R6: every input pattern and mode level at the final write
    for (int m = 0; m < 2; m++) begin
      for (int g = 0; g < 64; g++) begin
        wr(KA, K0); wr(KA, K1);
        gateIn = 6'(g); directMode = m[0];
        wr(KA, K2);
        check(allOn, (g == 63) && (m == 1), (g == 63) ? "R6" : "R5");
        gateIn = 6'h3F; directMode = 1'b1;
        // refused: sequence back at start, so lone KEY2 cannot grant
        wr(KA, K2);
        check(allOn, (g == 63) && (m == 1), "R5");
        flush();
      end
    end

    // R6: direct mode low between keys resets sequence
    wr(KA, K0); wr(KA, K1);
    directMode = 1'b0; idle(1); directMode = 1'b1;
    wr(KA, K2);
    check(allOn, 1'b0, "R6");
    flush();

    // R7: writes do not disturb a granted enable
    wr(KA, K0); wr(KA, K1); wr(KA, K2);
    for (int d = 0; d < 256; d += 17) begin
      wr(6'(d), 8'(d));
      check(allOn, 1'b1, "R7");
    end
    wr(KA, K0); check(allOn, 1'b1, "R7");

    // R8: each input low drops enable
    for (int b = 0; b < 6; b++) begin
      flush();
      wr(KA, K0); wr(KA, K1); wr(KA, K2);
      check(allOn, 1'b1, "R8");
      gateIn = 6'h3F & ~(6'd1 << b);
      idle(1);
      check(allOn, 1'b0, "R8");
      gateIn = 6'h3F;
      idle(1);
      check(allOn, 1'b0, "R8");
    end
    flush();
    wr(KA, K0); wr(KA, K1); wr(KA, K2);
    directMode = 1'b0; idle(1);
    check(allOn, 1'b0, "R8");
    flush();

    // R9: inputs low during early keys do not reset progress
    gateIn = 6'h00; wr(KA, K0);
    gateIn = 6'h15; wr(KA, K1);
    gateIn = 6'h3F; wr(KA, K2);
    check(allOn, 1'b1, "R9");
    flush();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule